// File: doc/BRIEF.md
# Two-Step Product Array Encoder

The block takes one information set and builds a 7x7 binary product array from it in two ordered steps. First, five 3-bit information symbols are encoded systematically into a seven-symbol Reed-Solomon word over GF(8). The word is laid out as a bit image: every array column holds one symbol, and array rows 0 to 2 hold bit planes 0 to 2 of the symbols. Array row 3 carries seven more information bits that the row code does not protect. Second, every one of the seven columns is treated as a 7-bit word whose first four bits are rows 0 to 3. A binary parity-check code, defined by a three-row check matrix, computes rows 4 to 6 from them.

The whole array is computed in the cycle the information set is accepted and is registered at that edge. It then leaves the block one 7-bit row per cycle, row 0 first, with a last flag on row 6. A new information set may be accepted while row 6 is on the output, so frames can follow each other with no idle cycle.

Top module: `prodcode_enc`

## Requirements
- R1: While reset is held and in the first cycle after its release, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: Symbol j (j = 0..4) is `in_sym_bits[3*j+2:3*j]`. Bit b of array column j in row b (b = 0..2) is bit b of symbol j. Columns 5 and 6 hold the two check symbols. These are chosen so that the polynomial whose coefficient of x^(6-j) is the symbol in column j is zero at alpha and at alpha^2, where alpha is a root of x^3 + x + 1 (symbol bit b is the coefficient of alpha^b).
- R3: Array row 3, column j, equals `in_extra_row[j]`.
- R4: For each column, rows 4, 5 and 6 are set so that, over the column bits r0..r6, r0^r1^r3^r4 = 0, r0^r2^r3^r5 = 0 and r1^r2^r3^r6 = 0.
- R5: When `in_valid` and `in_ready` are both 1 at a rising edge, rows 0 to 6 of that array appear on `out_row` in the seven following cycles, in order, with `out_valid` = 1. Bit j of `out_row` is column j.
- R6: `out_last` is 1 exactly on the cycle that carries row 6.
- R7: `in_ready` is 0 while rows 0 to 5 are on the output. An `in_valid` raised then neither starts a frame nor changes the frame in flight. When no frame is in flight and none was accepted, `out_valid` is 0.
- R8: An information set accepted while row 6 is on the output puts its row 0 on the output in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Information set present on the inputs |
| in_ready | output | 1 | Block can take an information set this cycle |
| in_sym_bits | input | 15 | Five 3-bit row-code information symbols, symbol j in bits 3j+2..3j |
| in_extra_row | input | 7 | Information bits for array row 3 |
| out_valid | output | 1 | `out_row` carries an array row |
| out_row | output | 7 | Current array row, bit j is column j |
| out_last | output | 1 | Current row is row 6 |

## Verification
The hardest case to reach from the ports is a new information set arriving exactly on the row-6 cycle, where the ready path and the frame end meet in one edge. The bench reaches it by calling its send task again as soon as the previous accept completes. The task then holds `in_valid` high through the busy cycles, so the accept lands on the row-6 cycle. A second case is a request driven while the block is busy, which must leave no trace. The bench checks it by comparing the streamed rows of the frame in flight and by confirming that no extra frame appears afterwards. The expected check symbols come from an exhaustive search for the unique pair that satisfies both root conditions, not from a division circuit.

// File: rtl/pce_pkg.sv
package pce_pkg;

    localparam int SYM_W     = 3;
    localparam int ROW_SYMS  = 7;
    localparam int DATA_SYMS = 5;
    localparam int RS_PAR    = ROW_SYMS - DATA_SYMS;
    localparam int COL_LEN   = 7;
    localparam int COL_DATA  = 4;
    localparam int CHK_ROWS  = COL_LEN - COL_DATA;
    localparam int IDX_W     = $clog2(COL_LEN);
    localparam int INFO_W    = DATA_SYMS * SYM_W;

    localparam logic [SYM_W:0] FIELD_POLY = 4'b1011;

    typedef logic [SYM_W-1:0]    sym_t;
    typedef logic [ROW_SYMS-1:0] row_t;
    typedef row_t [COL_LEN-1:0]  arr_t;
    typedef sym_t [ROW_SYMS-1:0] word_t;
    typedef sym_t [RS_PAR:0]     gen_t;

    // bit j of entry k marks column position j in check equation k
    localparam row_t [CHK_ROWS-1:0] COL_CHECK = {7'b1001110, 7'b0101101, 7'b0011011};

    function automatic sym_t gf_xtime(sym_t x);
        sym_t r;
        r = {x[SYM_W-2:0], 1'b0};
        if (x[SYM_W-1]) r = r ^ FIELD_POLY[SYM_W-1:0];
        return r;
    endfunction

    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t r;
        sym_t x;
        r = '0;
        x = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) r = r ^ x;
            x = gf_xtime(x);
        end
        return r;
    endfunction

    function automatic sym_t alpha_pow(int e);
        sym_t r;
        r = sym_t'(1);
        for (int i = 0; i < e; i++) r = gf_xtime(r);
        return r;
    endfunction

    // product of (x + alpha^k) for k = 1..RS_PAR, entry i = coefficient of x^i
    function automatic gen_t rs_generator();
        gen_t g;
        gen_t n;
        g    = '0;
        g[0] = sym_t'(1);
        for (int k = 1; k <= RS_PAR; k++) begin
            n = '0;
            for (int i = 0; i <= RS_PAR; i++) begin
                if (i > 0) n[i] = n[i] ^ g[i-1];
                n[i] = n[i] ^ gf_mul(g[i], alpha_pow(k));
            end
            g = n;
        end
        return g;
    endfunction

    localparam gen_t RS_GEN = rs_generator();

    // Horner evaluation, column 0 is the highest power
    function automatic sym_t word_eval(word_t w, sym_t pt);
        sym_t acc;
        acc = '0;
        for (int j = 0; j < ROW_SYMS; j++) acc = gf_mul(acc, pt) ^ w[j];
        return acc;
    endfunction

endpackage

// File: rtl/pce_rs_rows.sv
module pce_rs_rows
    import pce_pkg::*;
(
    input  logic [INFO_W-1:0] info_bits,
    output row_t [SYM_W-1:0]  rows_img
);

    sym_t [RS_PAR-1:0] rem_d;
    word_t             word_d;

    always_comb begin
        sym_t fb_d;
        rem_d = '0;
        for (int j = 0; j < DATA_SYMS; j++) begin
            fb_d = info_bits[j*SYM_W +: SYM_W] ^ rem_d[RS_PAR-1];
            for (int k = RS_PAR-1; k > 0; k--) begin
                rem_d[k] = rem_d[k-1] ^ gf_mul(fb_d, RS_GEN[k]);
            end
            rem_d[0] = gf_mul(fb_d, RS_GEN[0]);
        end
    end

    genvar gj, gb;
    generate
        for (gj = 0; gj < ROW_SYMS; gj++) begin : g_col
            if (gj < DATA_SYMS) begin : g_data
                assign word_d[gj] = info_bits[gj*SYM_W +: SYM_W];
            end else begin : g_par
                assign word_d[gj] = rem_d[ROW_SYMS-1-gj];
            end
            for (gb = 0; gb < SYM_W; gb++) begin : g_bit
                assign rows_img[gb][gj] = word_d[gj][gb];
            end
        end
    endgenerate

endmodule

// File: rtl/pce_col_code.sv
module pce_col_code
    import pce_pkg::*;
(
    input  row_t [COL_DATA-1:0] data_rows,
    output arr_t                full_arr
);

    genvar gr, gj, gk;
    generate
        for (gr = 0; gr < COL_DATA; gr++) begin : g_copy
            assign full_arr[gr] = data_rows[gr];
        end
        for (gj = 0; gj < ROW_SYMS; gj++) begin : g_col
            for (gk = 0; gk < CHK_ROWS; gk++) begin : g_chk
                logic par_d;
                always_comb begin
                    par_d = 1'b0;
                    for (int i = 0; i < COL_DATA; i++) begin
                        if (COL_CHECK[gk][i]) par_d = par_d ^ data_rows[i][gj];
                    end
                end
                assign full_arr[COL_DATA+gk][gj] = par_d;
            end
        end
    endgenerate

endmodule

// File: rtl/pce_streamer.sv
module pce_streamer
    import pce_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    input  arr_t frame_arr,
    output logic out_valid,
    output row_t out_row,
    output logic out_last
);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        arr_t             arr;
    } st_t;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COL_LEN-1);

    st_t  st_d, st_q;
    logic take_d;

    always_comb begin
        in_ready = !st_q.busy || (st_q.idx == LAST_IDX);
        take_d   = in_valid && in_ready;
        st_d     = st_q;
        if (st_q.busy) begin
            if (st_q.idx == LAST_IDX) st_d.busy = 1'b0;
            else                      st_d.idx  = st_q.idx + 1'b1;
        end
        if (take_d) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.arr  = frame_arr;
        end
        out_valid = st_q.busy;
        out_row   = st_q.arr[st_q.idx];
        out_last  = st_q.busy && (st_q.idx == LAST_IDX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_last_has_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    p_burst_unbroken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_last |=> out_valid);
    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_last |-> !in_ready);
    p_quiet_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last && !in_valid |=> !out_valid);
    p_chain_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last && in_valid |=> out_valid && !out_last);
    p_first_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> st_q.idx == '0);

endmodule

// File: rtl/prodcode_enc.sv
module prodcode_enc
    import pce_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [INFO_W-1:0] in_sym_bits,
    input  logic [ROW_SYMS-1:0] in_extra_row,
    output logic              out_valid,
    output logic [ROW_SYMS-1:0] out_row,
    output logic              out_last
);

    row_t [SYM_W-1:0]    rs_img;
    row_t [COL_DATA-1:0] col_in;
    arr_t                frame_arr;

    pce_rs_rows i_rows (
        .info_bits (in_sym_bits),
        .rows_img  (rs_img)
    );

    genvar gr;
    generate
        for (gr = 0; gr < COL_DATA; gr++) begin : g_colin
            if (gr < SYM_W) begin : g_rs
                assign col_in[gr] = rs_img[gr];
            end else begin : g_extra
                assign col_in[gr] = in_extra_row;
            end
        end
    endgenerate

    pce_col_code i_cols (
        .data_rows (col_in),
        .full_arr  (frame_arr)
    );

    pce_streamer i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .frame_arr (frame_arr),
        .out_valid (out_valid),
        .out_row   (out_row),
        .out_last  (out_last)
    );

    // root check of the row word built by the division circuit
    word_t chk_word;
    always_comb begin
        for (int j = 0; j < ROW_SYMS; j++) begin
            for (int b = 0; b < SYM_W; b++) chk_word[j][b] = frame_arr[b][j];
        end
    end

    p_row_roots_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |-> (word_eval(chk_word, alpha_pow(1)) == '0)
                              && (word_eval(chk_word, alpha_pow(2)) == '0));

    p_col_checks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |->
            ((^(col_in[0] & {ROW_SYMS{COL_CHECK[0][0]}}) ^ ^(col_in[1] & {ROW_SYMS{COL_CHECK[0][1]}})
              ^ ^(col_in[3] & {ROW_SYMS{COL_CHECK[0][3]}}) ^ ^frame_arr[4]) == 1'b0));

endmodule

// File: tb/test_prodcode_enc.sv
module test_prodcode_enc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [14:0] in_sym_bits = '0;
    logic [6:0]  in_extra_row = '0;
    logic        out_valid;
    logic [6:0]  out_row;
    logic        out_last;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [6:0] row;
        logic       last;
        int         idx;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    prodcode_enc i_prodcode_enc (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_sym_bits  (in_sym_bits),
        .in_extra_row (in_extra_row),
        .out_valid    (out_valid),
        .out_row      (out_row),
        .out_last     (out_last)
    );

    function automatic logic [2:0] tb_mul(logic [2:0] a, logic [2:0] b);
        logic [5:0] p;
        p = '0;
        for (int i = 0; i < 3; i++) if (b[i]) p = p ^ (6'(a) << i);
        for (int i = 5; i >= 3; i--) if (p[i]) p = p ^ (6'b001011 << (i - 3));
        return p[2:0];
    endfunction

    function automatic logic [2:0] tb_eval(logic [2:0] s [7], logic [2:0] pt);
        logic [2:0] acc;
        acc = '0;
        for (int j = 0; j < 7; j++) acc = tb_mul(acc, pt) ^ s[j];
        return acc;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic build_expect(logic [14:0] info, logic [6:0] extra);
        logic [2:0] s [7];
        logic [6:0] arr [7];
        int hits;
        for (int j = 0; j < 5; j++) s[j] = info[3*j +: 3];
        hits = 0;
        for (int p = 0; p < 64; p++) begin
            logic [2:0] t [7];
            t = s;
            t[5] = p[2:0];
            t[6] = p[5:3];
            if (tb_eval(t, 3'b010) == 3'b000 && tb_eval(t, 3'b100) == 3'b000) begin
                s[5] = t[5];
                s[6] = t[6];
                hits++;
            end
        end
        check(hits == 1, "R2", "unique check pair", hits, 1);
        for (int b = 0; b < 3; b++)
            for (int j = 0; j < 7; j++) arr[b][j] = s[j][b];
        arr[3] = extra;
        for (int j = 0; j < 7; j++) begin
            arr[4][j] = arr[0][j] ^ arr[1][j] ^ arr[3][j];
            arr[5][j] = arr[0][j] ^ arr[2][j] ^ arr[3][j];
            arr[6][j] = arr[1][j] ^ arr[2][j] ^ arr[3][j];
        end
        for (int r = 0; r < 7; r++) sb.push_back('{row: arr[r], last: (r == 6), idx: r});
    endtask

    // caller sits just after a falling edge; returns just after the falling edge following accept
    task automatic send(logic [14:0] info, logic [6:0] extra);
        in_valid     = 1'b1;
        in_sym_bits  = info;
        in_extra_row = extra;
        while (!in_ready) @(negedge clk);
        build_expect(info, extra);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: compare each streamed row against the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7", "row with no frame pending", int'(out_row), 0);
            end else begin
                exp_t e;
                string rq;
                e = sb.pop_front();
                rq = (e.idx < 3) ? "R2" : ((e.idx == 3) ? "R3" : "R4");
                check(out_row == e.row, rq, $sformatf("row %0d", e.idx), int'(out_row), int'(e.row));
                check(out_last == e.last, "R6", $sformatf("last on row %0d", e.idx), int'(out_last), int'(e.last));
            end
        end
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        check(out_valid == 1'b0 && out_last == 1'b0, "R1", "outputs in reset", int'({out_valid, out_last}), 0);
        check(in_ready == 1'b1, "R1", "ready in reset", int'(in_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R1", "after release", int'({out_valid, in_ready}), 1);

        send(15'h0000, 7'h00);
        check(out_valid == 1'b1, "R5", "row 0 follows accept", int'(out_valid), 1);
        repeat (8) @(negedge clk);
        send(15'h7FFF, 7'h7F);
        repeat (8) @(negedge clk);
        send(15'h0001, 7'h00);
        repeat (8) @(negedge clk);
        send(15'h0000, 7'h40);
        repeat (8) @(negedge clk);

        // R7: request while busy must be ignored
        send(15'h2A5C, 7'h35);
        repeat (2) @(negedge clk);
        check(in_ready == 1'b0, "R7", "ready low mid frame", int'(in_ready), 0);
        in_valid = 1'b1;
        in_sym_bits = 15'h1234;
        in_extra_row = 7'h11;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (8) @(negedge clk);
        check(out_valid == 1'b0, "R7", "no extra frame", int'(out_valid), 0);

        // R8: back-to-back frames
        send(15'h4E21, 7'h5A);
        send(15'h1B3F, 7'h26);
        check(out_valid == 1'b1 && out_last == 1'b0, "R8", "next frame row 0 with no gap", int'({out_valid, out_last}), 2);
        send(15'h6D07, 7'h0F);
        for (int k = 0; k < 8; k++) begin
            logic [14:0] v;
            v = 15'(k * 4099 + 77);
            send(v, 7'(k * 19 + 3));
        end
        repeat (10) @(negedge clk);
        check(sb.size() == 0, "R5", "all rows delivered", sb.size(), 0);
        check(out_valid == 1'b0, "R7", "idle at end", int'(out_valid), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule